// File: doc/BRIEF.md
# Dual-Lane ARX Quarter-Round Mixer

This block applies the add-rotate-xor quarter-round used by the BLAKE2s compression function to two independent lanes of four 32-bit words in a single invocation. Each lane carries its own words (a, b, c, d) and its own pair of message words: a first word consumed in the first half of the mix and a second word consumed in the second half. A round sequencer places two columns, or two diagonals, of the 4x4 working state on the two lanes and gets back the mixed words one cycle later.

A mode input lets the caller keep the b and d rows in a rotated storage form, which saves a rotation step in the surrounding datapath. In deferred mode the incoming b and d words are taken to hold a pending right-rotation, fixed by parameters, which the block undoes before using them. The outgoing b and d words are handed back still owing a right-rotation of 7 and 8 bits. In canonical mode no rotation is pending on either side. The underlying mixed values are the same in both modes.

Message scheduling, round sequencing, state storage and the final fold into the chaining value belong to the caller.

Top module: `qmix_dual`

## Requirements
- R1: First half of a lane: a := a + b + mx; d := ror(d ^ a, 16); c := c + d; b := ror(b ^ c, 12). With all words zero and mx = 1, my = 0, the lane returns a = 0x00000011, b = 0x20220202, c = 0x11010100, d = 0x11000100.
- R2: Second half repeats the four steps with my and rotations of 8 and 7. With all words zero, mx = 0 and my = 1, the lane returns a = 0x00000001, b = 0x00020000, c = 0x01000000, d = 0x01000000.
- R3: Every addition wraps modulo 2^32 and the carry out is dropped. All-ones inputs give the wrapped result.
- R4: The two lanes are independent. Lane 0 is bits [31:0] and lane 1 is bits [63:32] of each word port. Changing one lane's inputs leaves the other lane's outputs unchanged.
- R5: With defer_i = 1, each b_i word is rotated right by IN_BROT bits (default 7) and each d_i word by IN_DROT bits (default 8) before use.
- R6: With defer_i = 1, b_o equals the true b rotated left by 7 and d_o equals the true d rotated left by 8. a_o and c_o carry true values.
- R7: With defer_i = 0, no rotation is applied on input or output. The underlying results match those of deferred mode.
- R8: With REGISTERED = 1 (default), out_valid is high in exactly the cycle after a cycle with in_valid high, and low otherwise.
- R9: While rst_n is low, out_valid and all word outputs are zero.
- R10: Outputs hold their values across cycles in which in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input words valid this cycle |
| defer_i | input | 1 | 1: b/d use the rotated storage form; 0: canonical |
| a_i | input | 2x32 | Row a word per lane |
| b_i | input | 2x32 | Row b word per lane |
| c_i | input | 2x32 | Row c word per lane |
| d_i | input | 2x32 | Row d word per lane |
| mx_i | input | 2x32 | First-half message word per lane |
| my_i | input | 2x32 | Second-half message word per lane |
| out_valid | output | 1 | Output words valid |
| a_o | output | 2x32 | Mixed row a per lane |
| b_o | output | 2x32 | Mixed row b per lane, rotated form when deferred |
| c_o | output | 2x32 | Mixed row c per lane |
| d_o | output | 2x32 | Mixed row d per lane, rotated form when deferred |

## Verification
Two hand-computed answers pin the message words to the correct half and the rotation amounts to the correct steps. A swapped mx/my or an exchanged 16/12 pair changes those answers at once. All-ones operands expose an adder that keeps a carry or is too narrow. Deferred-mode runs feed pre-rotated b and d words and compare against canonical runs, so an input fix-up in the wrong direction, or an output rotation that is missing or swapped between b and d, shows as a mismatch. Directed steps check valid timing, output hold while idle, lane isolation, and clearing on a mid-run reset.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
  localparam int unsigned QW       = 32;
  localparam int unsigned OUT_BROT = 7;
  localparam int unsigned OUT_DROT = 8;
  localparam int unsigned HA_DROT  = 16;
  localparam int unsigned HA_BROT  = 12;
  localparam int unsigned HB_DROT  = 8;
  localparam int unsigned HB_BROT  = 7;

  typedef struct packed {
    logic [QW-1:0] a;
    logic [QW-1:0] b;
    logic [QW-1:0] c;
    logic [QW-1:0] d;
  } qm_quad_t;

  function automatic logic [QW-1:0] qm_ror(input logic [QW-1:0] x, input int unsigned n);
    logic [2*QW-1:0] t;
    t = {x, x} >> (n % QW);
    return t[QW-1:0];
  endfunction

  function automatic logic [QW-1:0] qm_rol(input logic [QW-1:0] x, input int unsigned n);
    return qm_ror(x, (QW - (n % QW)) % QW);
  endfunction

  // one half of the mix: add, xor-rotate, add, xor-rotate
  function automatic qm_quad_t qm_half(input qm_quad_t q, input logic [QW-1:0] m,
                                       input int unsigned rd, input int unsigned rb);
    qm_quad_t r;
    r.a = q.a + q.b + m;
    r.d = qm_ror(q.d ^ r.a, rd);
    r.c = q.c + r.d;
    r.b = qm_ror(q.b ^ r.c, rb);
    return r;
  endfunction
endpackage

// File: rtl/qmix_align.sv
module qmix_align
  import qmix_pkg::*;
#(
  parameter int unsigned IN_BROT = 7,
  parameter int unsigned IN_DROT = 8
) (
  input  logic     defer_i,
  input  qm_quad_t raw_q,
  output qm_quad_t true_q
);
  always_comb begin
    true_q = raw_q;
    if (defer_i) begin
      true_q.b = qm_ror(raw_q.b, IN_BROT);
      true_q.d = qm_ror(raw_q.d, IN_DROT);
    end
  end
endmodule

// File: rtl/qmix_lane_core.sv
module qmix_lane_core
  import qmix_pkg::*;
(
  input  qm_quad_t      in_q,
  input  logic [QW-1:0] mx,
  input  logic [QW-1:0] my,
  output qm_quad_t      mid_q,
  output qm_quad_t      out_q
);
  assign mid_q = qm_half(in_q, mx, HA_DROT, HA_BROT);
  assign out_q = qm_half(mid_q, my, HB_DROT, HB_BROT);
endmodule

// File: rtl/qmix_skew.sv
module qmix_skew
  import qmix_pkg::*;
(
  input  logic     defer_i,
  input  qm_quad_t true_q,
  output qm_quad_t store_q
);
  always_comb begin
    store_q = true_q;
    if (defer_i) begin
      store_q.b = qm_rol(true_q.b, OUT_BROT);
      store_q.d = qm_rol(true_q.d, OUT_DROT);
    end
  end
endmodule

// File: rtl/qmix_dual.sv
module qmix_dual
  import qmix_pkg::*;
#(
  parameter int unsigned LANES      = 2,
  parameter int unsigned IN_BROT    = 7,
  parameter int unsigned IN_DROT    = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      defer_i,
  input  logic [LANES-1:0][QW-1:0]  a_i,
  input  logic [LANES-1:0][QW-1:0]  b_i,
  input  logic [LANES-1:0][QW-1:0]  c_i,
  input  logic [LANES-1:0][QW-1:0]  d_i,
  input  logic [LANES-1:0][QW-1:0]  mx_i,
  input  logic [LANES-1:0][QW-1:0]  my_i,
  output logic                      out_valid,
  output logic [LANES-1:0][QW-1:0]  a_o,
  output logic [LANES-1:0][QW-1:0]  b_o,
  output logic [LANES-1:0][QW-1:0]  c_o,
  output logic [LANES-1:0][QW-1:0]  d_o
);
  // named internal results, visible to the bound checker
  logic [LANES-1:0][QW-1:0] canon_a, canon_b, canon_c, canon_d;
  logic [LANES-1:0][QW-1:0] sk_a, sk_b, sk_c, sk_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qm_quad_t raw_q, true_q, mid_q, res_q, st_q;
    assign raw_q = '{a: a_i[l], b: b_i[l], c: c_i[l], d: d_i[l]};

    qmix_align #(.IN_BROT(IN_BROT), .IN_DROT(IN_DROT)) u_align (
      .defer_i(defer_i), .raw_q(raw_q), .true_q(true_q));

    qmix_lane_core u_core (
      .in_q(true_q), .mx(mx_i[l]), .my(my_i[l]), .mid_q(mid_q), .out_q(res_q));

    qmix_skew u_skew (.defer_i(defer_i), .true_q(res_q), .store_q(st_q));

    assign canon_a[l] = res_q.a;
    assign canon_b[l] = res_q.b;
    assign canon_c[l] = res_q.c;
    assign canon_d[l] = res_q.d;
    assign sk_a[l]    = st_q.a;
    assign sk_b[l]    = st_q.b;
    assign sk_c[l]    = st_q.c;
    assign sk_d[l]    = st_q.d;
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        a_o <= '0;
        b_o <= '0;
        c_o <= '0;
        d_o <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          a_o <= sk_a;
          b_o <= sk_b;
          c_o <= sk_c;
          d_o <= sk_d;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid & rst_n;
    assign a_o = rst_n ? sk_a : '0;
    assign b_o = rst_n ? sk_b : '0;
    assign c_o = rst_n ? sk_c : '0;
    assign d_o = rst_n ? sk_d : '0;
  end
endmodule

// File: rtl/qmix_checker.sv
module qmix_checker
  import qmix_pkg::*;
#(
  parameter int unsigned LANES      = 2,
  parameter bit          REGISTERED = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     defer_i,
  input logic                     out_valid,
  input logic [LANES-1:0][QW-1:0] a_o,
  input logic [LANES-1:0][QW-1:0] b_o,
  input logic [LANES-1:0][QW-1:0] c_o,
  input logic [LANES-1:0][QW-1:0] d_o,
  input logic [LANES-1:0][QW-1:0] canon_a,
  input logic [LANES-1:0][QW-1:0] canon_b,
  input logic [LANES-1:0][QW-1:0] canon_c,
  input logic [LANES-1:0][QW-1:0] canon_d
);
  if (REGISTERED) begin : g_reg_chk
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    for (genvar l = 0; l < LANES; l++) begin : g_l
      a_r6_a_true: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> a_o[l] == $past(canon_a[l]));
      a_r6_c_true: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> c_o[l] == $past(canon_c[l]));
      a_r6_b_owes_rot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && defer_i) |=> qm_ror(b_o[l], OUT_BROT) == $past(canon_b[l]));
      a_r6_d_owes_rot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && defer_i) |=> qm_ror(d_o[l], OUT_DROT) == $past(canon_d[l]));
      a_r7_b_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !defer_i) |=> b_o[l] == $past(canon_b[l]));
      a_r7_d_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !defer_i) |=> d_o[l] == $past(canon_d[l]));
      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(a_o[l]) && $stable(b_o[l]) && $stable(c_o[l]) && $stable(d_o[l])));
    end
  end else begin : g_comb_chk
    a_r8_comb_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end
endmodule

bind qmix_dual qmix_checker #(.LANES(LANES), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .defer_i(defer_i),
  .out_valid(out_valid), .a_o(a_o), .b_o(b_o), .c_o(c_o), .d_o(d_o),
  .canon_a(canon_a), .canon_b(canon_b), .canon_c(canon_c), .canon_d(canon_d));

// File: tb/tb_qmix_dual.sv
module tb_qmix_dual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic defer_i = 1'b0;
  logic [1:0][31:0] a_i = '0, b_i = '0, c_i = '0, d_i = '0, mx_i = '0, my_i = '0;
  logic out_valid;
  logic [1:0][31:0] a_o, b_o, c_o, d_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  qmix_dual dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .defer_i(defer_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i), .mx_i(mx_i), .my_i(my_i),
    .out_valid(out_valid), .a_o(a_o), .b_o(b_o), .c_o(c_o), .d_o(d_o));

  // rows: a, b, c, d, mx, my
  localparam logic [31:0] VEC [6][6] = '{
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000},
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000001, 32'h00000000},
    '{32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210, 32'h0F0F0F0F, 32'hF0F0F0F0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{32'h80000001, 32'h7FFFFFFF, 32'h13579BDF, 32'h2468ACE0, 32'hCAFEF00D, 32'h00000100},
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000001}
  };

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  // reference: returns {a,b,c,d}
  function automatic logic [127:0] ref_mix(input logic [31:0] a, b, c, d, mx, my);
    logic [31:0] w [4];
    logic [32:0] s;
    w[0] = a; w[1] = b; w[2] = c; w[3] = d;
    for (int k = 0; k < 2; k++) begin
      s = {1'b0, w[0]} + {1'b0, w[1]};
      s = {1'b0, s[31:0]} + {1'b0, (k == 0) ? mx : my};
      w[0] = s[31:0];
      w[3] = rotr(w[3] ^ w[0], (k == 0) ? 16 : 8);
      s = {1'b0, w[2]} + {1'b0, w[3]};
      w[2] = s[31:0];
      w[1] = rotr(w[1] ^ w[2], (k == 0) ? 12 : 7);
    end
    return {w[0], w[1], w[2], w[3]};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic load_row(input int lane, input int r);
    a_i[lane] = VEC[r][0]; b_i[lane] = VEC[r][1]; c_i[lane] = VEC[r][2];
    d_i[lane] = VEC[r][3]; mx_i[lane] = VEC[r][4]; my_i[lane] = VEC[r][5];
  endtask

  // drive one valid cycle; returns at the negedge after the capturing edge
  task automatic fire(input logic dm);
    defer_i = dm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // compare both lanes against reference; deferred: b/d compared in stored form
  task automatic check_lanes(input string req, input logic dm,
                             input logic [1:0][31:0] ta, tb, tc, td, tx, ty);
    logic [127:0] e;
    for (int l = 0; l < 2; l++) begin
      e = ref_mix(ta[l], tb[l], tc[l], td[l], tx[l], ty[l]);
      check(req, "a", a_o[l], e[127:96]);
      check(req, "b", b_o[l], dm ? rotl(e[95:64], 7) : e[95:64]);
      check(req, "c", c_o[l], e[63:32]);
      check(req, "d", d_o[l], dm ? rotl(e[31:0], 8) : e[31:0]);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0][31:0] ta, tb, tc, td, tx, ty;
    logic [31:0] held;
    @(negedge clk); @(negedge clk);
    // R9: reset state
    check("R9", "out_valid in reset", {31'b0, out_valid}, 32'h0);
    check("R9", "a_o in reset", a_o[0], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "idle out_valid", {31'b0, out_valid}, 32'h0);

    // table walk: canonical (R7) and deferred (R5, R6) on every row pair
    for (int i = 0; i < 6; i++) begin
      load_row(0, i);
      load_row(1, (i + 3) % 6);
      ta = a_i; tb = b_i; tc = c_i; td = d_i; tx = mx_i; ty = my_i;
      fire(1'b0);
      check("R8", "out_valid after input", {31'b0, out_valid}, 32'h1);
      check_lanes("R7", 1'b0, ta, tb, tc, td, tx, ty);
      if (i == 1) begin  // R1 known answer
        check("R1", "a", a_o[0], 32'h00000011);
        check("R1", "b", b_o[0], 32'h20220202);
        check("R1", "c", c_o[0], 32'h11010100);
        check("R1", "d", d_o[0], 32'h11000100);
      end
      if (i == 5) begin  // R2 known answer
        check("R2", "a", a_o[0], 32'h00000001);
        check("R2", "b", b_o[0], 32'h00020000);
        check("R2", "c", c_o[0], 32'h01000000);
        check("R2", "d", d_o[0], 32'h01000000);
      end
      if (i == 3) check_lanes("R3", 1'b0, ta, tb, tc, td, tx, ty);
      // deferred: store b,d pre-rotated left so the block's right fix-up recovers them
      for (int l = 0; l < 2; l++) begin
        b_i[l] = rotl(tb[l], 7);
        d_i[l] = rotl(td[l], 8);
      end
      fire(1'b1);
      check_lanes("R5", 1'b1, ta, tb, tc, td, tx, ty);
      check("R6", "a true in deferred", a_o[0], ref_mix(ta[0], tb[0], tc[0], td[0], tx[0], ty[0]) >> 96);
    end

    // R8/R10: no valid -> out_valid low, outputs held while inputs change
    held = b_o[1];
    a_i = '1; b_i = '1; c_i = '0; mx_i = 32'h5;
    @(negedge clk);
    check("R8", "out_valid without input", {31'b0, out_valid}, 32'h0);
    check("R10", "b held", b_o[1], held);
    @(negedge clk);
    check("R10", "b still held", b_o[1], held);

    // R4: lane 1 fixed, lane 0 varied -> lane 1 outputs unchanged
    load_row(1, 2);
    load_row(0, 0);
    fire(1'b0);
    held = d_o[1];
    load_row(0, 4);
    fire(1'b0);
    check("R4", "lane1 d unchanged", d_o[1], held);
    check("R4", "lane0 a follows own input", a_o[0],
          ref_mix(VEC[4][0], VEC[4][1], VEC[4][2], VEC[4][3], VEC[4][4], VEC[4][5]) >> 96);

    // R9: mid-run reset clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "out_valid after reset", {31'b0, out_valid}, 32'h0);
    check("R9", "a_o after reset", a_o[0], 32'h0);
    check("R9", "d_o after reset", d_o[1], 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule